// File: doc/BRIEF.md
# TLP Transmit Lane Aligner

This block turns one transaction layer packet into a sequence of 128-bit beats on a valid/ready transmit stream. A packet arrives as a command (three or four header dwords, the payload length in dwords, bit 2 of the payload address and a bad-packet flag), followed by its payload on a separate 128-bit input stream. Each payload input beat carries up to four dwords, packed from the low lane up.

The aligner decides where the first payload dword lands. It chooses a lane whose odd/even parity matches the payload address qword alignment, so the header and the payload can share a beat. Where the parity calls for it, the aligner inserts a zero filler dword or leaves a lane unused. It counts the output beats and marks the first and last beat of each packet. On the last beat it reports whether the data ends in the lower half of the bus, and it carries the bad-packet flag. All outputs come from a register stage, so they stay stable while the downstream side stalls.

Top module: `tlp_tx_aligner`

## Requirements
- R1: Each beat carries four dwords, with lane k in bits [32k+31:32k]. On the first beat, header dword k sits in lane k.
- R2: With a 3-dword header and address bit 2 = 1, payload dword 0 sits in lane 3 of the first beat. Payload dword 1 onward continue from lane 0 of the second beat.
- R3: With a 3-dword header and address bit 2 = 0, lane 3 of the first beat is zero and payload dword 0 sits in lane 0 of the second beat.
- R4: With a 4-dword header and address bit 2 = 0, the first beat holds only the four header dwords, and payload dword 0 sits in lane 0 of the second beat.
- R5: With a 4-dword header and address bit 2 = 1, lane 0 of the second beat is a zero filler and payload dword 0 sits in lane 1.
- R6: A packet spans ceil(total/4) beats. Here total is the header size when the length is zero, otherwise the first payload slot (3, 4 or 5) plus the length. Start-of-packet is high on the first beat only and end-of-packet on the last beat only. No beat is sent outside a packet.
- R7: The empty flag is high on a last beat whose final valid dword is in lane 0 or 1. It is low when the final valid dword is in lane 2 or 3, and low on every beat that is not last.
- R8: On the last beat, every lane above the final valid dword is zero, whatever the payload input carried there. The header input's lane 3 is never used for a 3-dword header.
- R9: When a packet's command carries the bad flag, the error output is high on that packet's last beat. It is low on every other beat and for clean packets.
- R10: While the output valid is high and ready is low, valid stays high and data, start, end, empty and error hold their values. A beat is taken only when valid and ready are both high.
- R11: A zero-length packet is a single beat carrying start and end with empty low. It takes no payload input beat.
- R12: A packet takes exactly ceil(length/4) payload input beats, and payload ready is never high while payload valid is low. A command is accepted only while no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Packet command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_hdr | input | 128 | Header dwords, dword k in bits [32k+31:32k] |
| cmd_hdr4 | input | 1 | 1 = 4-dword header, 0 = 3-dword header |
| cmd_addr_b2 | input | 1 | Bit 2 of the payload start address |
| cmd_len | input | LEN_W | Payload length in dwords (0 = no payload) |
| cmd_err | input | 1 | Mark this packet as bad |
| pay_valid | input | 1 | Payload input beat present |
| pay_ready | output | 1 | Payload input beat taken |
| pay_data | input | 128 | Payload dwords packed from lane 0 |
| tx_valid | output | 1 | Output beat present |
| tx_ready | input | 1 | Downstream takes the beat |
| tx_data | output | 128 | Output beat, four dword lanes |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_empty | output | 1 | Last beat ends in the lower 64 bits |
| tx_err | output | 1 | Packet is bad (on the last beat) |

## Verification
Backpressure and the header beat that pulls in a payload dword can land in the same cycle. In that case the output stage must hold a stalled beat while the payload input is still waiting to be taken. The bench drives the downstream ready low two cycles out of three and gaps the payload input every other cycle, with a 3-dword, odd-address packet. It judges each held beat against the value it showed when the stall began. It also counts the payload handshakes against ceil(length/4), so a beat taken twice or skipped during a stall shows up as wrong lanes or a wrong count.

// File: rtl/tlp_align_pkg.sv
package tlp_align_pkg;

    localparam int DW_W       = 32;
    localparam int LANES      = 4;
    localparam int BEAT_W     = DW_W * LANES;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int SLOT_W     = LANE_IDX_W + 1;

    typedef logic [LANES-1:0][DW_W-1:0] beat_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HEAD,
        PH_BODY
    } phase_e;

    // Per-packet placement decisions, fixed when the command is taken.
    typedef struct packed {
        logic                  hdr4;
        logic [LANE_IDX_W-1:0] rot;
        logic                  hdr_pay;
        logic [SLOT_W-1:0]     last_lanes;
        logic                  empty;
        logic                  err;
    } plan_t;

    function automatic logic [SLOT_W-1:0] hdr_dwords(input logic hdr4);
        return hdr4 ? SLOT_W'(4) : SLOT_W'(3);
    endfunction

    // Dword slot (counted from the first beat) of payload dword 0.
    // Odd slot when address bit 2 is set, even slot otherwise.
    function automatic logic [SLOT_W-1:0] first_pay_slot(input logic hdr4,
                                                        input logic odd);
        if (hdr4)
            return odd ? SLOT_W'(5) : SLOT_W'(4);
        else
            return odd ? SLOT_W'(3) : SLOT_W'(4);
    endfunction

endpackage

// File: rtl/tlp_pkt_plan.sv
module tlp_pkt_plan
    import tlp_align_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             hdr4,
    input  logic             odd,
    input  logic [LEN_W-1:0] len,
    input  logic             err,
    output plan_t            plan,
    output logic [LEN_W-1:0] n_out,
    output logic [LEN_W-1:0] n_in
);

    localparam int TOT_W = LEN_W + 2;

    logic [SLOT_W-1:0] slot;
    logic [TOT_W-1:0]  total;
    logic [TOT_W-1:0]  last_idx;
    logic [TOT_W-1:0]  out_sum;
    logic [TOT_W-1:0]  in_sum;

    always_comb begin
        slot     = first_pay_slot(hdr4, odd);
        total    = (len == '0) ? TOT_W'(hdr_dwords(hdr4))
                               : TOT_W'(len) + TOT_W'(slot);
        last_idx = total - TOT_W'(1);
        out_sum  = total + TOT_W'(LANES - 1);
        in_sum   = TOT_W'(len) + TOT_W'(LANES - 1);
        n_out    = LEN_W'(out_sum >> LANE_IDX_W);
        n_in     = LEN_W'(in_sum >> LANE_IDX_W);

        plan.hdr4       = hdr4;
        plan.rot        = slot[LANE_IDX_W-1:0];
        plan.hdr_pay    = (slot < hdr_dwords(1'b1)) && (len != '0);
        plan.last_lanes = {1'b0, last_idx[LANE_IDX_W-1:0]} + SLOT_W'(1);
        plan.empty      = (last_idx[LANE_IDX_W-1:0] < LANE_IDX_W'(LANES / 2));
        plan.err        = err;
    end

endmodule

// File: rtl/tlp_lane_mux.sv
module tlp_lane_mux
    import tlp_align_pkg::*;
(
    input  logic                  hdr_beat,
    input  logic                  hdr4,
    input  logic                  hdr_pay,
    input  logic [LANE_IDX_W-1:0] rot,
    input  logic                  last_beat,
    input  logic [SLOT_W-1:0]     last_lanes,
    input  beat_t                 hdr,
    input  beat_t                 cur,
    input  beat_t                 prev,
    output beat_t                 beat
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SLOT_W-1:0] win;
        logic [DW_W-1:0]   body_dw;
        logic [DW_W-1:0]   lane_dw;

        // Window of eight dwords: previous input beat low, current high.
        always_comb begin
            win     = SLOT_W'(g + LANES) - {1'b0, rot};
            body_dw = win[LANE_IDX_W] ? cur[win[LANE_IDX_W-1:0]]
                                      : prev[win[LANE_IDX_W-1:0]];
            if (hdr_beat) begin
                if (SLOT_W'(g) < hdr_dwords(hdr4))
                    lane_dw = hdr[g];
                else if (hdr_pay)
                    lane_dw = cur[0];
                else
                    lane_dw = '0;
            end else begin
                lane_dw = body_dw;
            end
            if (last_beat && (SLOT_W'(g) >= last_lanes))
                lane_dw = '0;
        end

        assign beat[g] = lane_dw;
    end

endmodule

// File: rtl/tlp_beat_ctrl.sv
module tlp_beat_ctrl
    import tlp_align_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  plan_t            plan_in,
    input  logic [LEN_W-1:0] n_out_in,
    input  logic [LEN_W-1:0] n_in_in,
    input  logic             pay_valid,
    input  logic             load_en,
    output logic             cmd_ready,
    output logic             cmd_take,
    output plan_t            plan_q,
    output logic             fire,
    output logic             need_in,
    output logic             hdr_beat,
    output logic             last_beat
);

    phase_e           phase;
    logic [LEN_W-1:0] out_left;
    logic [LEN_W-1:0] in_left;

    always_comb begin
        cmd_ready = (phase == PH_IDLE);
        cmd_take  = cmd_valid && cmd_ready;
        hdr_beat  = (phase == PH_HEAD);
        last_beat = (out_left == LEN_W'(1));
        need_in   = hdr_beat ? plan_q.hdr_pay : (in_left != '0);
        fire      = (phase != PH_IDLE) && load_en && (!need_in || pay_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            out_left <= '0;
            in_left  <= '0;
            plan_q   <= '0;
        end else if (cmd_take) begin
            phase    <= PH_HEAD;
            out_left <= n_out_in;
            in_left  <= n_in_in;
            plan_q   <= plan_in;
        end else if (fire) begin
            out_left <= out_left - LEN_W'(1);
            if (need_in)
                in_left <= in_left - LEN_W'(1);
            phase <= last_beat ? PH_IDLE : PH_BODY;
        end
    end

    assert_beats_left_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (out_left != '0));

    assert_payload_drained_R12: assert property (@(posedge clk) disable iff (rst)
        (fire && last_beat) |-> (in_left == (need_in ? LEN_W'(1) : LEN_W'(0))));

    assert_cmd_idle_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_take |=> (phase == PH_HEAD));

endmodule

// File: rtl/tlp_tx_aligner.sv
module tlp_tx_aligner
    import tlp_align_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BEAT_W-1:0] cmd_hdr,
    input  logic              cmd_hdr4,
    input  logic              cmd_addr_b2,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_err,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [BEAT_W-1:0] pay_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BEAT_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_empty,
    output logic              tx_err
);

    plan_t            plan_new;
    plan_t            plan_q;
    logic [LEN_W-1:0] n_out;
    logic [LEN_W-1:0] n_in;
    logic             cmd_take;
    logic             fire;
    logic             need_in;
    logic             hdr_beat;
    logic             last_beat;
    logic             load_en;
    beat_t            hdr_q;
    beat_t            prev_q;
    beat_t            cur_beat;
    beat_t            next_beat;

    logic              out_valid_q;
    logic [BEAT_W-1:0] out_data_q;
    logic              out_sop_q;
    logic              out_eop_q;
    logic              out_empty_q;
    logic              out_err_q;

    assign cur_beat  = pay_data;
    assign load_en   = !out_valid_q || tx_ready;
    assign pay_ready = fire && need_in;

    tlp_pkt_plan #(.LEN_W(LEN_W)) u_plan (
        .hdr4  (cmd_hdr4),
        .odd   (cmd_addr_b2),
        .len   (cmd_len),
        .err   (cmd_err),
        .plan  (plan_new),
        .n_out (n_out),
        .n_in  (n_in)
    );

    tlp_beat_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .plan_in   (plan_new),
        .n_out_in  (n_out),
        .n_in_in   (n_in),
        .pay_valid (pay_valid),
        .load_en   (load_en),
        .cmd_ready (cmd_ready),
        .cmd_take  (cmd_take),
        .plan_q    (plan_q),
        .fire      (fire),
        .need_in   (need_in),
        .hdr_beat  (hdr_beat),
        .last_beat (last_beat)
    );

    tlp_lane_mux u_mux (
        .hdr_beat   (hdr_beat),
        .hdr4       (plan_q.hdr4),
        .hdr_pay    (plan_q.hdr_pay),
        .rot        (plan_q.rot),
        .last_beat  (last_beat),
        .last_lanes (plan_q.last_lanes),
        .hdr        (hdr_q),
        .cur        (cur_beat),
        .prev       (prev_q),
        .beat       (next_beat)
    );

    // Header and carry registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q  <= '0;
            prev_q <= '0;
        end else begin
            if (cmd_take)
                hdr_q <= cmd_hdr;
            if (fire) begin
                if (need_in)
                    prev_q <= cur_beat;
                else if (hdr_beat)
                    prev_q <= '0;
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
            out_sop_q   <= 1'b0;
            out_eop_q   <= 1'b0;
            out_empty_q <= 1'b0;
            out_err_q   <= 1'b0;
        end else if (load_en) begin
            out_valid_q <= fire;
            if (fire) begin
                out_data_q  <= next_beat;
                out_sop_q   <= hdr_beat;
                out_eop_q   <= last_beat;
                out_empty_q <= last_beat && plan_q.empty;
                out_err_q   <= last_beat && plan_q.err;
            end
        end
    end

    assign tx_valid = out_valid_q;
    assign tx_data  = out_data_q;
    assign tx_sop   = out_sop_q;
    assign tx_eop   = out_eop_q;
    assign tx_empty = out_empty_q;
    assign tx_err   = out_err_q;

    // Tracks whether the downstream side is inside a packet.
    logic in_pkt;
    always_ff @(posedge clk) begin
        if (rst)
            in_pkt <= 1'b0;
        else if (tx_valid && tx_ready)
            in_pkt <= !tx_eop;
    end

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
            && $stable(tx_eop) && $stable(tx_empty) && $stable(tx_err)));

    assert_sop_start_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !in_pkt) |-> tx_sop);

    assert_sop_once_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && in_pkt) |-> !tx_sop);

    assert_empty_last_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_empty) |-> tx_eop);

    assert_err_last_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_err) |-> tx_eop);

    assert_pay_handshake_R12: assert property (@(posedge clk) disable iff (rst)
        pay_ready |-> pay_valid);

endmodule

// File: tb/tlp_tx_aligner_bench.sv
module tlp_tx_aligner_bench;

    localparam int LEN_W = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [127:0]      cmd_hdr;
    logic              cmd_hdr4;
    logic              cmd_addr_b2;
    logic [LEN_W-1:0]  cmd_len;
    logic              cmd_err;
    logic              pay_valid;
    logic              pay_ready;
    logic [127:0]      pay_data;
    logic              tx_valid;
    logic              tx_ready;
    logic [127:0]      tx_data;
    logic              tx_sop;
    logic              tx_eop;
    logic              tx_empty;
    logic              tx_err;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    tlp_tx_aligner #(.LEN_W(LEN_W)) u_tlp_tx_aligner (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_hdr     (cmd_hdr),
        .cmd_hdr4    (cmd_hdr4),
        .cmd_addr_b2 (cmd_addr_b2),
        .cmd_len     (cmd_len),
        .cmd_err     (cmd_err),
        .pay_valid   (pay_valid),
        .pay_ready   (pay_ready),
        .pay_data    (pay_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .tx_sop      (tx_sop),
        .tx_eop      (tx_eop),
        .tx_empty    (tx_empty),
        .tx_err      (tx_err)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_val(input logic [7:0] id, input int k);
        return {8'hE0, id, 8'h00, 8'(k)};
    endfunction

    function automatic logic [31:0] pay_val(input logic [7:0] id, input int i);
        return {id, 8'h5A, 16'(i)};
    endfunction

    // One packet: drive command and payload, take and judge every output beat.
    // rmode 1: downstream ready one cycle in three. pmode 1: payload gapped.
    task automatic run_pkt(input string tag, input bit h4, input bit b2, input int n,
                           input bit er, input int rmode, input int pmode,
                           input logic [7:0] id);
        logic [31:0]  dw [0:63];
        logic [127:0] exp_beat;
        logic [127:0] held_data;
        logic [3:0]   held_flags;
        int hl, st, total, nout, nin, bi, pi, t;
        bit sent, stalled, eop_e, emp_e;
        hl = h4 ? 4 : 3;
        st = h4 ? (b2 ? 5 : 4) : (b2 ? 3 : 4);
        for (int k = 0; k < 64; k++) dw[k] = 32'h0;
        for (int k = 0; k < hl; k++) dw[k] = hdr_val(id, k);
        for (int i = 0; i < n; i++) dw[st + i] = pay_val(id, i);
        total = (n == 0) ? hl : st + n;
        nout  = (total + 3) / 4;
        nin   = (n + 3) / 4;
        bi = 0; pi = 0; t = 0; sent = 0; stalled = 0;
        held_data = '0; held_flags = '0;
        while (bi < nout && t < 2000) begin
            @(negedge clk);
            t++;
            cmd_valid   = !sent;
            cmd_hdr4    = h4;
            cmd_addr_b2 = b2;
            cmd_len     = LEN_W'(n);
            cmd_err     = er;
            for (int k = 0; k < 4; k++)
                cmd_hdr[32*k +: 32] = (k < hl) ? hdr_val(id, k) : 32'hCAFE_0003;
            pay_valid = (pi < nin) && (pmode == 0 || (t % 2) == 0);
            for (int l = 0; l < 4; l++)
                pay_data[32*l +: 32] = (4*pi + l < n) ? pay_val(id, 4*pi + l)
                                                      : (32'hBAD0_0000 | 32'(l));
            tx_ready = (rmode == 0) || ((t % 3) == 0);
            #3;
            if (stalled) begin
                chk(tx_valid == 1'b1, "R10 valid held", 128'(tx_valid), 128'(1));
                chk(tx_data == held_data, "R10 data held", tx_data, held_data);
                chk({tx_sop, tx_eop, tx_empty, tx_err} == held_flags, "R10 flags held",
                    128'({tx_sop, tx_eop, tx_empty, tx_err}), 128'(held_flags));
            end
            if (tx_valid && tx_ready) begin
                exp_beat = {dw[4*bi+3], dw[4*bi+2], dw[4*bi+1], dw[4*bi]};
                eop_e = (bi == nout - 1);
                emp_e = eop_e && (((total - 1) % 4) < 2);
                chk(tx_data == exp_beat, {tag, " lanes"}, tx_data, exp_beat);
                chk(tx_sop == (bi == 0), "R6 sop", 128'(tx_sop), 128'(bi == 0));
                chk(tx_eop == eop_e, "R6 eop", 128'(tx_eop), 128'(eop_e));
                chk(tx_empty == emp_e, "R7 empty", 128'(tx_empty), 128'(emp_e));
                chk(tx_err == (er && eop_e), "R9 err", 128'(tx_err), 128'(er && eop_e));
                bi++;
            end
            stalled    = tx_valid && !tx_ready;
            held_data  = tx_data;
            held_flags = {tx_sop, tx_eop, tx_empty, tx_err};
            if (pay_valid && pay_ready) pi++;
            if (cmd_valid && cmd_ready) sent = 1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        pay_valid = 1'b0;
        tx_ready  = 1'b1;
        chk(bi == nout, "R6 beat count", 128'(bi), 128'(nout));
        chk(pi == nin, "R12 payload beats taken", 128'(pi), 128'(nin));
        repeat (3) @(negedge clk);
        #3;
        chk(tx_valid == 1'b0, "R6 no extra beat", 128'(tx_valid), 128'(0));
        chk(cmd_ready == 1'b1, "R12 idle accepts command", 128'(cmd_ready), 128'(1));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_hdr = '0; cmd_hdr4 = 1'b0; cmd_addr_b2 = 1'b0;
        cmd_len = '0; cmd_err = 1'b0; pay_valid = 1'b0; pay_data = '0; tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        chk(tx_valid == 1'b0, "R6 reset no beat", 128'(tx_valid), 128'(0));
        chk(cmd_ready == 1'b1, "R12 reset idle", 128'(cmd_ready), 128'(1));
        chk(pay_ready == 1'b0, "R12 reset no payload take", 128'(pay_ready), 128'(0));
    endtask

    task automatic t_hdr3_odd();
        run_pkt("R1 R2 R8 3dw odd n6", 1'b0, 1'b1, 6, 1'b0, 0, 0, 8'h11);
        run_pkt("R2 R8 3dw odd n1", 1'b0, 1'b1, 1, 1'b0, 0, 0, 8'h12);
    endtask

    task automatic t_hdr3_even();
        run_pkt("R1 R3 R8 3dw even n5", 1'b0, 1'b0, 5, 1'b0, 0, 0, 8'h21);
    endtask

    task automatic t_hdr4_even();
        run_pkt("R1 R4 R8 4dw even n8", 1'b1, 1'b0, 8, 1'b0, 0, 0, 8'h31);
        run_pkt("R4 R7 4dw even n1", 1'b1, 1'b0, 1, 1'b0, 0, 0, 8'h32);
    endtask

    task automatic t_hdr4_odd();
        run_pkt("R1 R5 R8 4dw odd n3", 1'b1, 1'b1, 3, 1'b0, 0, 0, 8'h41);
        run_pkt("R5 R8 4dw odd n10", 1'b1, 1'b1, 10, 1'b0, 0, 1, 8'h42);
    endtask

    task automatic t_no_payload();
        run_pkt("R11 3dw zero length", 1'b0, 1'b1, 0, 1'b0, 0, 0, 8'h51);
        run_pkt("R11 4dw zero length", 1'b1, 1'b0, 0, 1'b0, 0, 0, 8'h52);
    endtask

    task automatic t_error();
        run_pkt("R9 bad 4dw odd n7", 1'b1, 1'b1, 7, 1'b1, 0, 0, 8'h61);
        run_pkt("R9 bad zero length", 1'b0, 1'b0, 0, 1'b1, 1, 0, 8'h62);
    endtask

    task automatic t_backpressure();
        run_pkt("R10 R2 stalled 3dw odd n9", 1'b0, 1'b1, 9, 1'b0, 1, 1, 8'h71);
        run_pkt("R10 R3 stalled 3dw even n4", 1'b0, 1'b0, 4, 1'b1, 1, 1, 8'h72);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_hdr3_odd();
        t_hdr3_even();
        t_hdr4_even();
        t_hdr4_odd();
        t_no_payload();
        t_error();
        t_backpressure();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule